// File: doc/BRIEF.md
# Direct-Mapped Translation Buffer with Per-Access Permission Tags

This block translates virtual addresses to physical addresses through a small direct-mapped table. Every slot holds one physical page base and three tags, one for each kind of access: load, store and instruction fetch. A tag is written only when the page grants that kind of access. A permission check on a hit is therefore nothing more than a tag compare in the bank that belongs to the access.

When a lookup misses, the block records the request and raises `busy`. It then asks an external page-table walker for the page-table entry through a hold-until-acknowledge handshake. When the entry returns, the block works out the effective permissions and compares them with what the access needs. In supervisor mode the supervisor permission bits take the place of the user bits. If the access is allowed, the slot is refilled. If not, the block pulses `fault`, reports the kind of fault and latches the faulting virtual address. The requester keeps its request up while `busy` is high and replays it once `busy` falls. A `flush` pulse invalidates every tag in every bank.

Top module: `tlb_dm`

## Requirements
- R1: The slot index is the virtual page number (`lk_vaddr[15:8]` with the default 8 offset bits) modulo ENTRIES, which is a power of two. Pages with different indexes coexist. A refill at an index replaces the page that was there before.
- R2: `lk_hit` is high in the same cycle as `lk_valid` when `busy` is low and the selected bank holds a tag equal to `lk_vaddr` with its page-offset bits cleared. On a hit, `lk_paddr` is the stored page base ORed with the page offset.
- R3: A lookup that misses while `busy` is low makes `busy` and `walk_req` high from the next cycle on, with `walk_vaddr` equal to the missed address. These stay unchanged until `walk_ack`. While `busy` is high, no lookup hits and no new miss is taken.
- R4: Entry layout: bit 0 is user read, bit 1 user write, bit 2 user execute, bits 3 to 5 are supervisor read/write/execute, bit 6 is valid, and bits 14:7 are the PPN. The effective permission is bits 2:0 in user mode and bits 5:3 in supervisor mode. An access faults when the valid bit or its own effective bit (read for load, write for store, execute for fetch) is clear.
- R5: A fault gives a one-cycle `fault` pulse in the cycle after `walk_ack`. In that cycle `fault_kind` is 0 for load, 1 for store or 2 for fetch, and `bad_vaddr` holds the faulting address until the next fault. A faulting refill writes nothing.
- R6: A refill that does not fault writes every bank at the slot. Each bank gets the expected tag if its effective permission bit is set and all ones (invalid) if it is not. The page base is the PPN shifted above the offset. `busy` falls in the cycle after `walk_ack`.
- R7: After `flush`, every lookup misses from the next cycle on. A flush in the same cycle as `walk_ack` wins, and the refill is dropped.
- R8: After reset, `busy`, `walk_req` and `fault` are low, `bad_vaddr` is 0 and every lookup misses.
- R9: `lk_kind` encoding: 0 is load, 1 is store, 2 is fetch, and 3 is treated as a load in lookup, permission check and fault kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all tags |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_kind | input | 2 | Access kind (R9) |
| lk_super | input | 1 | Supervisor-mode access |
| lk_hit | output | 1 | Translation found and permitted |
| lk_paddr | output | PPN_W+PG_BITS | Physical address on a hit |
| busy | output | 1 | Miss outstanding, lookups held off |
| walk_req | output | 1 | Entry requested from the walker |
| walk_vaddr | output | VA_W | Address to be walked |
| walk_ack | input | 1 | Walker returns an entry |
| walk_pte | input | PPN_W+7 | Entry returned by the walker |
| fault | output | 1 | Access fault pulse |
| fault_kind | output | 2 | 0 load, 1 store, 2 fetch fault |
| bad_vaddr | output | VA_W | Last faulting virtual address |

## Verification
`lk_hit` and `lk_paddr` come from combinational logic, so the bench drives a lookup just after a falling edge and reads them a fraction of a nanosecond later, before the next rising edge. In that way a pure probe never starts a walk. `busy`, `walk_req` and `walk_vaddr` are due one cycle after the missing lookup. `fault`, `bad_vaddr`, the refilled tags and the fall of `busy` are due one cycle after `walk_ack`. The bench samples each of these at the falling edge that follows the rising edge which takes the cause. The sweep covers every combination of the seven permission and valid bits, both modes and all three access kinds, and probes all three banks after each refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  // bank numbering doubles as the fault-kind code
  localparam int BANK_LD = 0;
  localparam int BANK_ST = 1;
  localparam int BANK_IF = 2;
  localparam int NBANKS  = 3;

  // entry layout
  localparam int PERM_W    = 6;
  localparam int SUP_SHIFT = 3;
  localparam int VALID_BIT = 6;
  localparam int PPN_LSB   = 7;

  function automatic logic [1:0] bank_of(acc_e k);
    case (k)
      ACC_STORE: bank_of = 2'(BANK_ST);
      ACC_FETCH: bank_of = 2'(BANK_IF);
      default:   bank_of = 2'(BANK_LD);
    endcase
  endfunction

endpackage

// File: rtl/tlb_bank.sv
module tlb_bank #(
  parameter int          W         = 16,
  parameter int          DEPTH     = 4,
  parameter bit          FLUSHABLE = 1'b1,
  parameter logic [W-1:0] RST_VAL  = '0,
  localparam int         IDX_W     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data
);

  logic [W-1:0] slot_q [DEPTH];
  logic [W-1:0] slot_d [DEPTH];
  logic [DEPTH-1:0] slot_en;
  logic clr;

  assign clr = FLUSHABLE ? flush : 1'b0;

  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      slot_en[e] = clr | (wr_en && (wr_idx == IDX_W'(e)));
      slot_d[e]  = clr ? RST_VAL : wr_data;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[e] <= RST_VAL;
      else if (slot_en[e]) slot_q[e] <= slot_d[e];
    end
  end

  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/tlb_perm_eval.sv
module tlb_perm_eval
  import tlb_pkg::*;
(
  input  logic [PERM_W:0]      pte_lo,
  input  acc_e                 kind,
  input  logic                 sup,
  output logic [NBANKS-1:0]    grant,
  output logic                 deny
);

  logic [PERM_W-1:0] eff;
  logic [1:0]        need;

  always_comb begin
    eff  = sup ? (pte_lo[PERM_W-1:0] >> SUP_SHIFT) : pte_lo[PERM_W-1:0];
    grant[BANK_LD] = eff[0];
    grant[BANK_ST] = eff[1];
    grant[BANK_IF] = eff[2];
    need = bank_of(kind);
    deny = !pte_lo[VALID_BIT] || !grant[need];
  end

endmodule

// File: rtl/tlb_miss_ctrl.sv
module tlb_miss_ctrl
  import tlb_pkg::*;
#(
  parameter int VA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic            hit_raw,
  input  logic [VA_W-1:0] lk_vaddr,
  input  acc_e            lk_kind,
  input  logic            lk_super,
  input  logic            walk_ack,
  input  logic            deny,
  output logic            busy,
  output logic [VA_W-1:0] pend_vaddr,
  output acc_e            pend_kind,
  output logic            pend_super,
  output logic            fill_ok,
  output logic            fault,
  output logic [1:0]      fault_kind,
  output logic [VA_W-1:0] bad_vaddr
);

  logic busy_q, busy_d, fault_q, fault_d;
  logic cap_en, done;
  logic [VA_W-1:0] pva_q, bad_q;
  acc_e  pkind_q;
  logic  psup_q;
  logic [1:0] fkind_q;

  always_comb begin
    cap_en  = !busy_q && lk_valid && !hit_raw;
    done    = busy_q && walk_ack;
    busy_d  = busy_q;
    if (cap_en)    busy_d = 1'b1;
    else if (done) busy_d = 1'b0;
    fault_d = done && deny;
    fill_ok = done && !deny;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      fault_q <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pva_q   <= '0;
      pkind_q <= ACC_LOAD;
      psup_q  <= 1'b0;
    end else if (cap_en) begin
      pva_q   <= lk_vaddr;
      pkind_q <= lk_kind;
      psup_q  <= lk_super;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_q   <= '0;
      fkind_q <= 2'(BANK_LD);
    end else if (fault_d) begin
      bad_q   <= pva_q;
      fkind_q <= bank_of(pkind_q);
    end
  end

  assign busy       = busy_q;
  assign pend_vaddr = pva_q;
  assign pend_kind  = pkind_q;
  assign pend_super = psup_q;
  assign fault      = fault_q;
  assign fault_kind = fkind_q;
  assign bad_vaddr  = bad_q;

endmodule

// File: rtl/tlb_dm.sv
module tlb_dm
  import tlb_pkg::*;
#(
  parameter int VA_W    = 16,
  parameter int PG_BITS = 8,
  parameter int PPN_W   = 8,
  parameter int ENTRIES = 4,
  localparam int PA_W   = PPN_W + PG_BITS,
  localparam int PTE_W  = PPN_LSB + PPN_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [1:0]       lk_kind,
  input  logic             lk_super,
  output logic             lk_hit,
  output logic [PA_W-1:0]  lk_paddr,
  output logic             busy,
  output logic             walk_req,
  output logic [VA_W-1:0]  walk_vaddr,
  input  logic             walk_ack,
  input  logic [PTE_W-1:0] walk_pte,
  output logic             fault,
  output logic [1:0]       fault_kind,
  output logic [VA_W-1:0]  bad_vaddr
);

  localparam logic [VA_W-1:0] TAG_NONE = '1;

  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [VA_W-1:0]   rd_tag [NBANKS];
  logic [VA_W-1:0]   exp_tag, fill_tag;
  logic [PA_W-1:0]   base_rd, fill_base;
  logic [NBANKS-1:0] grant;
  logic [1:0]        sel;
  logic              hit_raw, deny, fill_ok, fill_go, pend_super;
  logic [VA_W-1:0]   pend_vaddr;
  acc_e              pend_kind;

  // lookup side
  assign rd_idx  = lk_vaddr[PG_BITS +: IDX_W];
  assign exp_tag = {lk_vaddr[VA_W-1:PG_BITS], {PG_BITS{1'b0}}};
  assign sel     = bank_of(acc_e'(lk_kind));
  assign hit_raw = (rd_tag[sel] == exp_tag);
  assign lk_hit  = lk_valid && !busy && hit_raw;
  assign lk_paddr = base_rd | PA_W'(lk_vaddr[PG_BITS-1:0]);

  // refill side
  assign wr_idx    = pend_vaddr[PG_BITS +: IDX_W];
  assign fill_tag  = {pend_vaddr[VA_W-1:PG_BITS], {PG_BITS{1'b0}}};
  assign fill_base = {walk_pte[PPN_LSB +: PPN_W], {PG_BITS{1'b0}}};
  assign fill_go   = fill_ok && !flush;
  assign walk_req  = busy;
  assign walk_vaddr = pend_vaddr;

  for (genvar k = 0; k < NBANKS; k++) begin : g_tag
    tlb_bank #(
      .W(VA_W), .DEPTH(ENTRIES), .FLUSHABLE(1'b1), .RST_VAL(TAG_NONE)
    ) u_tag (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush),
      .wr_en  (fill_go),
      .wr_idx (wr_idx),
      .wr_data(grant[k] ? fill_tag : TAG_NONE),
      .rd_idx (rd_idx),
      .rd_data(rd_tag[k])
    );
  end

  tlb_bank #(
    .W(PA_W), .DEPTH(ENTRIES), .FLUSHABLE(1'b0), .RST_VAL('0)
  ) u_base (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (1'b0),
    .wr_en  (fill_go),
    .wr_idx (wr_idx),
    .wr_data(fill_base),
    .rd_idx (rd_idx),
    .rd_data(base_rd)
  );

  tlb_perm_eval u_perm (
    .pte_lo(walk_pte[PERM_W:0]),
    .kind  (pend_kind),
    .sup   (pend_super),
    .grant (grant),
    .deny  (deny)
  );

  tlb_miss_ctrl #(.VA_W(VA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .hit_raw   (hit_raw),
    .lk_vaddr  (lk_vaddr),
    .lk_kind   (acc_e'(lk_kind)),
    .lk_super  (lk_super),
    .walk_ack  (walk_ack),
    .deny      (deny),
    .busy      (busy),
    .pend_vaddr(pend_vaddr),
    .pend_kind (pend_kind),
    .pend_super(pend_super),
    .fill_ok   (fill_ok),
    .fault     (fault),
    .fault_kind(fault_kind),
    .bad_vaddr (bad_vaddr)
  );

endmodule

// File: rtl/tlb_dm_chk.sv
module tlb_dm_chk #(
  parameter int VA_W    = 16,
  parameter int PG_BITS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               lk_valid,
  input logic [VA_W-1:0]    lk_vaddr,
  input logic               lk_hit,
  input logic [PG_BITS-1:0] lk_poff,
  input logic               busy,
  input logic               walk_req,
  input logic [VA_W-1:0]    walk_vaddr,
  input logic               walk_ack,
  input logic               fault,
  input logic [VA_W-1:0]    bad_vaddr
);

  p_miss_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !busy && !lk_hit |=> busy && walk_req && walk_vaddr == $past(lk_vaddr));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !walk_ack |=> busy && $stable(walk_vaddr));

  p_ack_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && walk_ack |=> !busy);

  p_fault_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(busy && walk_ack) && bad_vaddr == $past(walk_vaddr));

  p_fault_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  p_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_poff == lk_vaddr[PG_BITS-1:0]);

endmodule

bind tlb_dm tlb_dm_chk #(.VA_W(VA_W), .PG_BITS(PG_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .lk_valid  (lk_valid),
  .lk_vaddr  (lk_vaddr),
  .lk_hit    (lk_hit),
  .lk_poff   (lk_paddr[PG_BITS-1:0]),
  .busy      (busy),
  .walk_req  (walk_req),
  .walk_vaddr(walk_vaddr),
  .walk_ack  (walk_ack),
  .fault     (fault),
  .bad_vaddr (bad_vaddr)
);

// File: tb/tlb_dm_test.sv
`timescale 1ns/1ps
module tlb_dm_test;

  logic        clk = 1'b0;
  logic        rst_n, flush, lk_valid, lk_super, walk_ack;
  logic [15:0] lk_vaddr, walk_vaddr, bad_vaddr, lk_paddr;
  logic [1:0]  lk_kind, fault_kind;
  logic [14:0] walk_pte;
  logic        lk_hit, busy, walk_req, fault;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tlb_dm uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
    .lk_vaddr(lk_vaddr), .lk_kind(lk_kind), .lk_super(lk_super),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .busy(busy), .walk_req(walk_req),
    .walk_vaddr(walk_vaddr), .walk_ack(walk_ack), .walk_pte(walk_pte),
    .fault(fault), .fault_kind(fault_kind), .bad_vaddr(bad_vaddr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // effective permission bits {x,w,r} per R4
  function automatic logic [2:0] eff_perm(input logic [6:0] p, input bit sup);
    return sup ? p[5:3] : p[2:0];
  endfunction

  function automatic int kbank(input logic [1:0] k);
    return (k == 2'd3) ? 0 : int'(k);
  endfunction

  // combinational probe inside one low phase; never reaches a rising edge
  task automatic look(input logic [15:0] va, input logic [1:0] k, input bit sup,
                      output logic h, output logic [15:0] pa);
    lk_valid = 1'b1; lk_vaddr = va; lk_kind = k; lk_super = sup;
    #0.2;
    h = lk_hit; pa = lk_paddr;
    lk_valid = 1'b0;
  endtask

  // full miss, walk and refill; returns at the falling edge after the ack edge
  task automatic fill(input logic [15:0] va, input logic [1:0] k, input bit sup,
                      input logic [14:0] pte, input bit chk_walk);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_kind = k; lk_super = sup;
    @(negedge clk);
    if (chk_walk) begin
      chk(busy && walk_req, "R3 busy/walk_req after miss", {busy, walk_req}, 2'b11);
      chk(walk_vaddr == va, "R3 walk_vaddr", walk_vaddr, va);
    end
    walk_ack = 1'b1; walk_pte = pte;
    @(negedge clk);
    walk_ack = 1'b0; lk_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic h;
    logic [15:0] pa;
    rst_n = 1'b0; flush = 1'b0; lk_valid = 1'b0; lk_super = 1'b0;
    lk_vaddr = '0; lk_kind = '0; walk_ack = 1'b0; walk_pte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(!busy && !walk_req && !fault, "R8 idle after reset", {busy, walk_req, fault}, 3'b000);
    chk(bad_vaddr == 16'h0, "R8 bad_vaddr reset", bad_vaddr, 16'h0);
    look(16'h0000, 2'd0, 1'b0, h, pa);
    chk(!h, "R8 miss after reset", h, 1'b0);

    // R1 index placement and replacement
    fill(16'h1011, 2'd0, 1'b0, {8'hA1, 7'h7f}, 1'b1);
    fill(16'h1122, 2'd0, 1'b0, {8'hB2, 7'h7f}, 1'b0);
    look(16'h1033, 2'd0, 1'b0, h, pa);
    chk(h && pa == 16'hA133, "R1 slot0 page", {h, pa}, {1'b1, 16'hA133});
    look(16'h1144, 2'd0, 1'b0, h, pa);
    chk(h && pa == 16'hB244, "R1 slot1 page", {h, pa}, {1'b1, 16'hB244});
    fill(16'h1455, 2'd0, 1'b0, {8'hC3, 7'h7f}, 1'b0);
    look(16'h1000, 2'd0, 1'b0, h, pa);
    chk(!h, "R1 replaced page misses", h, 1'b0);
    look(16'h1466, 2'd0, 1'b0, h, pa);
    chk(h && pa == 16'hC366, "R1 new page hits", {h, pa}, {1'b1, 16'hC366});
    look(16'h1177, 2'd0, 1'b0, h, pa);
    chk(h, "R1 other slot kept", h, 1'b1);

    // R3 walk held while the ack is late; cached page does not hit while busy
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = 16'h2201; lk_kind = 2'd0; lk_super = 1'b0;
    @(negedge clk);
    lk_vaddr = 16'h1466;
    for (int c = 0; c < 3; c++) begin
      #0.2;
      chk(busy && walk_vaddr == 16'h2201, "R3 walk held", {busy, walk_vaddr}, {1'b1, 16'h2201});
      chk(!lk_hit, "R3 no hit while busy", lk_hit, 1'b0);
      @(negedge clk);
    end
    walk_ack = 1'b1; walk_pte = {8'h5D, 7'h41};
    @(negedge clk);
    walk_ack = 1'b0; lk_valid = 1'b0;
    chk(!busy, "R6 busy falls after ack", busy, 1'b0);
    look(16'h2209, 2'd0, 1'b0, h, pa);
    chk(h && pa == 16'h5D09, "R6 late refill hits", {h, pa}, {1'b1, 16'h5D09});

    // R7 flush in the ack cycle wins over refill
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = 16'h3301; lk_kind = 2'd0;
    @(negedge clk);
    walk_ack = 1'b1; walk_pte = {8'h77, 7'h7f}; flush = 1'b1;
    @(negedge clk);
    walk_ack = 1'b0; flush = 1'b0; lk_valid = 1'b0;
    look(16'h3301, 2'd0, 1'b0, h, pa);
    chk(!h, "R7 refill dropped by flush", h, 1'b0);
    look(16'h1466, 2'd0, 1'b0, h, pa);
    chk(!h, "R7 old page flushed", h, 1'b0);

    // R9 kind 3 acts as a load
    fill(16'h4412, 2'd0, 1'b0, {8'h19, 7'h41}, 1'b0);
    look(16'h4413, 2'd3, 1'b0, h, pa);
    chk(h && pa == 16'h1913, "R9 kind3 uses load bank", {h, pa}, {1'b1, 16'h1913});
    look(16'h4413, 2'd1, 1'b0, h, pa);
    chk(!h, "R9 store bank empty", h, 1'b0);

    // sweep: every permission/valid pattern, both modes, all kinds
    for (int p = 0; p < 128; p++) begin
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < 3; k++) begin
          logic [15:0] va;
          logic [7:0]  ppn;
          logic [2:0]  g;
          bit          exp_f;
          va    = {8'(p * 5 + k * 37 + s * 101), 8'(p ^ 8'h5a)};
          ppn   = 8'(~p ^ k);
          g     = eff_perm(7'(p), s[0]);
          exp_f = !p[6] || !g[kbank(2'(k))];
          @(negedge clk);
          flush = 1'b1;
          @(negedge clk);
          flush = 1'b0;
          look(va, 2'(k), s[0], h, pa);
          chk(!h, "R7 miss after flush", h, 1'b0);
          fill(va, 2'(k), s[0], {ppn, 7'(p)}, (p % 16) == 0);
          #0.1;
          chk(fault == exp_f, "R4 fault decision", fault, exp_f);
          if (exp_f) begin
            chk(fault_kind == 2'(k) && bad_vaddr == va, "R5 fault kind/address",
                {fault_kind, bad_vaddr}, {2'(k), va});
            for (int k2 = 0; k2 < 3; k2++) begin
              look(va, 2'(k2), s[0], h, pa);
              chk(!h, "R5 no refill on fault", h, 1'b0);
            end
          end else begin
            for (int k2 = 0; k2 < 3; k2++) begin
              look(va, 2'(k2), s[0], h, pa);
              chk(h == g[k2], "R6 bank tag follows permission", h, g[k2]);
              if (k2 == k)
                chk(pa == {ppn, va[7:0]}, "R2 physical address", pa, {ppn, va[7:0]});
            end
          end
          @(negedge clk);
          chk(!fault, "R5 fault is one cycle", fault, 1'b0);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule